// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block sequences cache maintenance work toward a tag array. A requester issues commands one at a time on a command port. A single-line command names one line and is done when that one line request is acknowledged. A range command needs two writes. The first write records a start address and picks the operation, clean or invalidate. The second write gives an inclusive end address and starts the walk. The engine then sends one request per 32-byte line, in ascending order, on a valid/acknowledge port. It moves to the next line only after the current request is acknowledged.

While a walk or a single-line request is pending, `busy` holds the requester off. A range whose start and end fall in different pages is refused. Nothing is walked and a sticky error flag is raised. A range whose end lies below its start finishes at once and does no work. Only physical addresses are handled. The tag array itself and any write-back data path are outside this block.

Top module: `cache_range_engine`

## Requirements
- R1: A single-line command (kind 1 = clean, 2 = invalidate, 3 = clean-and-invalidate) issues exactly one line request. Its op code equals the kind value (1 clean, 2 invalidate, 3 clean-and-invalidate) and its address is the command address with the low 5 bits cleared.
- R2: A range-start write (kind 4 = clean range, kind 5 = invalidate range) records the start line and arms the engine. It issues no line request and does not raise busy.
- R3: A range-end write (kind 6) to an armed engine walks every line from the start line to the end line inclusive, in ascending order, one request per line, with addresses 32 bytes apart.
- R4: A line request holds its valid, address and op stable until it is acknowledged. The address advances by 32 only after an acknowledge.
- R5: Busy rises in the cycle after an accepted single-line command or a launching end write. It falls in the cycle after the last acknowledge. Any command presented while busy is ignored.
- R6: If the start and end addresses differ in any bit at or above the page-offset bits (page size parameter, default 4096 bytes), the error flag is set, no line request is issued, and busy stays low.
- R7: If the end line is below the start line, no line request is issued, busy stays low, and the error flag is left clear.
- R8: An end write that is not preceded by a start write since the last command is ignored. It causes no request and no change in busy or error. The armed state is also cleared by a single-line command and by any end write.
- R9: The error flag stays set until the next command that takes effect while idle clears it.
- R10: The range operation is the one chosen by the start write. Op code 1 is clean and op code 2 is invalidate.
- R11: After reset, busy, the line request valid and the error flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken only when not busy |
| cmdKind | input | 3 | Command kind: 1-3 single-line, 4/5 range start, 6 range end |
| cmdAddr | input | ADDR_W | Byte address of the command |
| busy | output | 1 | Stall to the requester while work is pending |
| rangeError | output | 1 | Sticky flag for a refused cross-page range |
| lineReqValid | output | 1 | A line request is presented |
| lineReqOp | output | 2 | Line op: 1 clean, 2 invalidate, 3 clean-and-invalidate |
| lineReqAddr | output | ADDR_W | Line-aligned address of the request |
| lineReqAck | input | 1 | Downstream accepts the current request |

## Verification
The bench checks the inclusive end of a walk. A design that stops one line early, or runs one line past the end, leaves the scoreboard holding a line or receiving an extra one. Unaligned start and end addresses are used to catch a design that rounds the end down the wrong way or rounds the start up. The checks also cover a start and end one line apart across a page edge, an end below its start, and an end write with no start before it. These catch designs that walk across the page, raise a false error, or walk from stale registers. Long acknowledge stalls with a command presented during the stall catch a design that advances without an acknowledge or accepts work while busy.

// File: rtl/cre_pkg.sv
package cre_pkg;
  // command kinds
  localparam logic [2:0] KIND_CLEAN1  = 3'd1;
  localparam logic [2:0] KIND_INV1    = 3'd2;
  localparam logic [2:0] KIND_CLINV1  = 3'd3;
  localparam logic [2:0] KIND_RCLEAN  = 3'd4;
  localparam logic [2:0] KIND_RINV    = 3'd5;
  localparam logic [2:0] KIND_REND    = 3'd6;

  // line operation codes
  localparam logic [1:0] OP_CLEAN = 2'd1;
  localparam logic [1:0] OP_INV   = 2'd2;
  localparam logic [1:0] OP_CLINV = 2'd3;

  typedef struct packed {
    logic       loadStart;
    logic       loadSingle;
    logic       launch;
    logic       advance;
    logic [1:0] op;
  } ctrlStrobes_t;
endpackage

// File: rtl/cre_datapath.sv
module cre_datapath
  import cre_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              rangeBad,
  output logic              rangeEmpty,
  output logic              atEnd,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqOp
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int LN_W      = ADDR_W - LINE_BITS;
  localparam int PG_SHIFT  = $clog2(PAGE_BYTES) - LINE_BITS;

  logic [LN_W-1:0] startLine, endLine, curLine;
  logic [LN_W-1:0] cmdLine;
  logic [1:0]      rangeOp;

  assign cmdLine = cmdAddr[ADDR_W-1:LINE_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startLine <= '0;
      endLine   <= '0;
      curLine   <= '0;
      rangeOp   <= OP_CLEAN;
      reqOp     <= OP_CLEAN;
    end else begin
      if (strb.loadStart) begin
        startLine <= cmdLine;
        rangeOp   <= strb.op;
      end
      if (strb.loadSingle) begin
        curLine <= cmdLine;
        endLine <= cmdLine;
        reqOp   <= strb.op;
      end else if (strb.launch) begin
        curLine <= startLine;
        endLine <= cmdLine;
        reqOp   <= rangeOp;
      end else if (strb.advance) begin
        curLine <= curLine + 1'b1;
      end
    end
  end

  generate
    if (PG_SHIFT >= LN_W) begin : g_onePage
      assign rangeBad = 1'b0;
    end else begin : g_pageCheck
      logic [LN_W-1:0] lineDiff;
      assign lineDiff = startLine ^ cmdLine;
      assign rangeBad = |lineDiff[LN_W-1:PG_SHIFT];
    end
  endgenerate

  assign rangeEmpty = cmdLine < startLine;
  assign atEnd      = curLine == endLine;
  assign reqAddr    = {curLine, {LINE_BITS{1'b0}}};
endmodule

// File: rtl/cre_ctrl.sv
module cre_ctrl
  import cre_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdKind,
  input  logic         rangeBad,
  input  logic         rangeEmpty,
  input  logic         atEnd,
  input  logic         lineReqAck,
  output ctrlStrobes_t strb,
  output logic         walking,
  output logic         rangeError
);
  typedef enum logic {S_IDLE, S_WALK} state_t;

  state_t state, stateNext;
  logic   armed, armedNext;
  logic   errNext;
  logic   take;

  assign take = cmdValid && (state == S_IDLE);

  always_comb begin
    strb      = '0;
    stateNext = state;
    armedNext = armed;
    errNext   = rangeError;
    if (state == S_WALK) begin
      if (lineReqAck) begin
        if (atEnd) stateNext = S_IDLE;
        else       strb.advance = 1'b1;
      end
    end else if (take) begin
      unique case (cmdKind)
        KIND_CLEAN1, KIND_INV1, KIND_CLINV1: begin
          strb.loadSingle = 1'b1;
          strb.op         = cmdKind[1:0];
          stateNext       = S_WALK;
          armedNext       = 1'b0;
          errNext         = 1'b0;
        end
        KIND_RCLEAN, KIND_RINV: begin
          strb.loadStart = 1'b1;
          strb.op        = (cmdKind == KIND_RINV) ? OP_INV : OP_CLEAN;
          armedNext      = 1'b1;
          errNext        = 1'b0;
        end
        KIND_REND: begin
          if (armed) begin
            armedNext = 1'b0;
            if (rangeBad) begin
              errNext = 1'b1;
            end else begin
              errNext = 1'b0;
              if (!rangeEmpty) begin
                strb.launch = 1'b1;
                stateNext   = S_WALK;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      armed      <= 1'b0;
      rangeError <= 1'b0;
    end else begin
      state      <= stateNext;
      armed      <= armedNext;
      rangeError <= errNext;
    end
  end

  assign walking = state == S_WALK;
endmodule

// File: rtl/cache_range_engine.sv
module cache_range_engine
  import cre_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              busy,
  output logic              rangeError,
  output logic              lineReqValid,
  output logic [1:0]        lineReqOp,
  output logic [ADDR_W-1:0] lineReqAddr,
  input  logic              lineReqAck
);
  ctrlStrobes_t strb;
  logic rangeBad, rangeEmpty, atEnd, walking;

  cre_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .rangeBad   (rangeBad),
    .rangeEmpty (rangeEmpty),
    .atEnd      (atEnd),
    .lineReqAck (lineReqAck),
    .strb       (strb),
    .walking    (walking),
    .rangeError (rangeError)
  );

  cre_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdAddr    (cmdAddr),
    .rangeBad   (rangeBad),
    .rangeEmpty (rangeEmpty),
    .atEnd      (atEnd),
    .reqAddr    (lineReqAddr),
    .reqOp      (lineReqOp)
  );

  assign busy         = walking;
  assign lineReqValid = walking;
endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rangeError,
  input logic              lineReqValid,
  input logic [1:0]        lineReqOp,
  input logic [ADDR_W-1:0] lineReqAddr,
  input logic              lineReqAck
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);

  // R1
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineReqValid |-> (lineReqAddr[LINE_BITS-1:0] == '0));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineReqValid && !lineReqAck) |=>
      (lineReqValid && $stable(lineReqAddr) && $stable(lineReqOp)));

  // R4
  req_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineReqValid && lineReqAck) |=>
      (!lineReqValid || lineReqAddr == $past(lineReqAddr) + ADDR_W'(LINE_BYTES)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(lineReqValid && lineReqAck)) |=> busy);

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rangeError) |-> (!busy && !lineReqValid));
endmodule

bind cache_range_engine cre_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (.*);

// File: tb/tb_cache_range_engine.sv
module tb_cache_range_engine;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdKind = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic          busy, rangeError, lineReqValid;
  logic [1:0]    lineReqOp;
  logic [AW-1:0] lineReqAddr;
  logic          lineReqAck = 1'b0;

  int  checks = 0;
  int  failures = 0;
  bit  stallAck = 1'b0;
  bit  doneFlag = 1'b0;
  int  ackCnt = 0;
  int  cycles = 0;

  logic [AW+1:0] expQ[$];
  string         tagQ[$];

  always #2.5 clk = ~clk;

  cache_range_engine dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .busy(busy), .rangeError(rangeError),
    .lineReqValid(lineReqValid), .lineReqOp(lineReqOp),
    .lineReqAddr(lineReqAddr), .lineReqAck(lineReqAck)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectLine(input logic [1:0] op, input logic [AW-1:0] a, input string tag);
    expQ.push_back({op, a & ~32'h1f});
    tagQ.push_back(tag);
  endtask

  task automatic expectRange(input logic [1:0] op, input logic [AW-1:0] s,
                             input logic [AW-1:0] e, input string tag);
    for (longint a = s & ~32'h1f; a <= (e & ~32'h1f); a += 32)
      expectLine(op, a[AW-1:0], tag);
  endtask

  // monitor: acknowledges requests and compares against the scoreboard
  always @(negedge clk) begin
    cycles++;
    if (!rstN) lineReqAck = 1'b0;
    else begin
      lineReqAck = lineReqValid && !stallAck && (ackCnt % 3 != 1);
      ackCnt++;
      if (lineReqAck) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected request", {lineReqOp, lineReqAddr}, 0);
        end else begin
          logic [AW+1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({lineReqOp, lineReqAddr} == e, t, "line request",
                {lineReqOp, lineReqAddr}, e);
        end
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = k; cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0; cmdKind = '0;
  endtask

  task automatic waitIdle(input string tag);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    check(!busy, tag, "busy at end", busy, 0);
    check(expQ.size() == 0, tag, "lines left", expQ.size(), 0);
  endtask

  task automatic finishRun;
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !lineReqValid && !rangeError, "R11", "reset outputs",
          {busy, lineReqValid, rangeError}, 0);
    rstN = 1'b1;

    // R1 single-line commands, unaligned addresses
    expectLine(2'd1, 32'h0000_1234, "R1");
    issue(3'd1, 32'h0000_1234);
    check(busy, "R5", "busy after single", busy, 1);
    waitIdle("R1");
    expectLine(2'd2, 32'h0000_0fff, "R1");
    issue(3'd2, 32'h0000_0fff);
    waitIdle("R1");
    expectLine(2'd3, 32'hffff_ffe1, "R1");
    issue(3'd3, 32'hffff_ffe1);
    waitIdle("R1");

    // R2 start write alone: no request, not busy
    issue(3'd4, 32'h0000_2000);
    check(!busy && !lineReqValid, "R2", "idle after start", busy, 0);
    // R3 R10 clean range of 8 lines
    expectRange(2'd1, 32'h2000, 32'h20e0, "R3");
    issue(3'd6, 32'h0000_20e0);
    check(busy, "R5", "busy after launch", busy, 1);
    waitIdle("R3");

    // R10 R3 invalidate range, unaligned ends
    issue(3'd5, 32'h0000_3045);
    expectRange(2'd2, 32'h3045, 32'h3061, "R10");
    issue(3'd6, 32'h0000_3061);
    waitIdle("R10");

    // R3 single-line range
    issue(3'd4, 32'h0000_4020);
    expectRange(2'd1, 32'h4020, 32'h403f, "R3");
    issue(3'd6, 32'h0000_403f);
    waitIdle("R3");

    // R3 full page
    issue(3'd5, 32'h0000_5000);
    expectRange(2'd2, 32'h5000, 32'h5fff, "R3");
    issue(3'd6, 32'h0000_5fff);
    waitIdle("R3");

    // R6 range across a page edge
    issue(3'd4, 32'h0000_6fe0);
    issue(3'd6, 32'h0000_7000);
    check(rangeError, "R6", "error flag", rangeError, 1);
    check(!busy && !lineReqValid, "R6", "no walk", busy, 0);
    repeat (5) @(negedge clk);
    // R9 error held, R8 ignored end does not clear it
    check(rangeError, "R9", "error held", rangeError, 1);
    issue(3'd6, 32'h0000_6fe0);
    check(rangeError && !busy, "R8", "ignored end", {rangeError, busy}, 2);
    expectLine(2'd1, 32'h0000_6fe0, "R9");
    issue(3'd1, 32'h0000_6fe0);
    check(!rangeError, "R9", "error cleared", rangeError, 0);
    waitIdle("R9");

    // R7 end below start
    issue(3'd4, 32'h0000_8100);
    issue(3'd6, 32'h0000_8000);
    check(!busy && !rangeError && !lineReqValid, "R7", "empty range",
          {busy, rangeError, lineReqValid}, 0);

    // R8 end after a completed range, and end after an intervening single
    issue(3'd6, 32'h0000_8200);
    check(!busy && !lineReqValid, "R8", "end without start", busy, 0);
    issue(3'd5, 32'h0000_9000);
    expectLine(2'd3, 32'h0000_a000, "R8");
    issue(3'd3, 32'h0000_a000);
    waitIdle("R8");
    issue(3'd6, 32'h0000_9100);
    repeat (3) @(negedge clk);
    check(!busy && !lineReqValid, "R8", "disarmed by single", busy, 0);

    // R4 R5 long stall, command presented while busy is ignored
    stallAck = 1'b1;
    issue(3'd4, 32'h0000_b040);
    expectRange(2'd1, 32'h0000_b040, 32'h0000_b0a0, "R5");
    issue(3'd6, 32'h0000_b0a0);
    repeat (20) @(negedge clk);
    check(busy && lineReqAddr == 32'h0000_b040, "R4", "held during stall",
          lineReqAddr, 32'h0000_b040);
    issue(3'd2, 32'h0000_c000);
    check(lineReqAddr == 32'h0000_b040 && lineReqOp == 2'd1, "R5",
          "command while busy", lineReqAddr, 32'h0000_b040);
    stallAck = 1'b0;
    waitIdle("R5");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0 && !lineReqValid, "R5", "no late request",
          lineReqValid, 0);
    finishRun();
  end
endmodule